// File: doc/BRIEF.md
# Performance Event Counter with Overflow Interrupt

This block is a 32-bit event counter for a performance monitoring unit. On every clock it adds the event count presented on a small input, from zero to four events. It treats its most significant bit as an overflow flag. That flag is set when the count climbs past the halfway point of its range, so an interrupt handler can find the counters that overflowed even if it runs many cycles later.

Privileged software can load any value through a write port. A user-mode alias also exists. It reads the same value, but writes through it have no effect. The interrupt request is a level signal. It is the overflow flag gated by three enables: a global one, one for this counter, and an external interrupt enable. The request stays high until software clears the top bit or drops one of the enables.

Top module: `perfEventCounter`

## Requirements
- R1: A hard reset (`rstN` low) clears the counter to 0x0000_0000. The first value seen after reset release is zero.
- R2: In a cycle without a privileged write, the counter rises by `evtInc`, where `evtInc` is 0, 1, 2, 3 or 4. The new value is visible after that clock edge.
- R3: An `evtInc` value of 5, 6 or 7 is treated as 4.
- R4: The count is modulo 2^32. A step that passes 0xFFFF_FFFF wraps through zero, and the wrap clears bit 31. For example, 0xFFFF_FFFE plus 4 gives 0x0000_0002.
- R5: Counting sets bit 31 only when the value moves from below 0x8000_0000 to 0x8000_0000 or above. Once set, bit 31 stays set while counting continues, until a wrap or a write clears it.
- R6: A privileged write (`wrEn` high) loads `wrData` on the clock edge. If an increment is presented in the same cycle, the written value wins and that increment is discarded.
- R7: A write through the user alias (`wrUser` high, `wrEn` low) is ignored. The counter advances exactly as if no write had been presented.
- R8: The privileged read view `rdData` and the user read view `rdUserData` always show the same counter value.
- R9: `irq` is high exactly when bit 31 of the counter and `globalEn`, `counterEn` and `extIntEn` are all high. Counting continues while `irq` is masked.
- R10: Writing a value with bit 31 set into a counter whose bit 31 was clear raises `irq` in the very next cycle, before any further event is counted, when all three enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| evtInc | input | 3 | Events to add this cycle (0 to 4; larger values are treated as 4) |
| wrEn | input | 1 | Privileged write strobe |
| wrUser | input | 1 | Write strobe through the user alias (ignored) |
| wrData | input | 32 | Value to load on a privileged write |
| globalEn | input | 1 | Global interrupt enable of the monitor |
| counterEn | input | 1 | Interrupt enable for this counter |
| extIntEn | input | 1 | External interrupt enable |
| rdData | output | 32 | Privileged read view of the counter |
| rdUserData | output | 32 | User read-only view of the counter |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check the following:
- the per-cycle step, including the clamping of large increments;
- the precedence of a write over an increment;
- the equality of the two read views;
- the gating of the interrupt by the three enables;
- that bit 31 stays set while counting continues;
- that a loaded overflowed value raises the request on the next cycle.

Some behaviour only the bench scenarios can show. These are the exact wrap results of steps of 2 to 4 that straddle 0xFFFF_FFFF, and the precise crossing of 0x8000_0000 from 0x7FFF_FFFx. They also include the continued counting while the interrupt is masked, and the long random mix of writes, ignored user writes and enable patterns.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;
  localparam int INC_W   = 3;
  localparam int INC_MAX = 4;

  typedef struct packed {
    logic             load;
    logic             add;
    logic [INC_W-1:0] step;
  } ctlStrobes_t;
endpackage

// File: rtl/perfcnt_ctrl.sv
module perfcnt_ctrl
  import perfcnt_pkg::*;
(
  input  logic             wrEn,
  input  logic             wrUser,
  input  logic [INC_W-1:0] evtInc,
  input  logic             ovFlag,
  input  logic             globalEn,
  input  logic             counterEn,
  input  logic             extIntEn,
  output ctlStrobes_t      strobes,
  output logic             irq
);
  localparam logic [INC_W-1:0] STEP_CAP = INC_W'(INC_MAX);

  logic [INC_W-1:0] clampedStep;
  logic             userWriteSeen;

  always_comb begin
    clampedStep = (evtInc > STEP_CAP) ? STEP_CAP : evtInc;
  end

  // The user alias never loads: its strobe is observed only to show it is dropped.
  assign userWriteSeen = wrUser & ~wrEn;

  always_comb begin
    strobes      = '0;
    strobes.load = wrEn;
    strobes.add  = ~wrEn & ((clampedStep != '0) | userWriteSeen);
    strobes.step = wrEn ? '0 : clampedStep;
  end

  assign irq = ovFlag & globalEn & counterEn & extIntEn;
endmodule

// File: rtl/perfcnt_dp.sv
module perfcnt_dp
  import perfcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntValue,
  output logic             ovFlag
);
  localparam int TOP = CNT_W - 1;

  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] sumNext;

  assign sumNext = cntReg + CNT_W'(strobes.step);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (strobes.load) begin
      cntReg <= wrData;
    end else if (strobes.add) begin
      cntReg <= sumNext;
    end
  end

  assign cntValue = cntReg;
  assign ovFlag   = cntReg[TOP];
endmodule

// File: rtl/perfEventCounter.sv
module perfEventCounter
  import perfcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [INC_W-1:0] evtInc,
  input  logic             wrEn,
  input  logic             wrUser,
  input  logic [CNT_W-1:0] wrData,
  input  logic             globalEn,
  input  logic             counterEn,
  input  logic             extIntEn,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] rdUserData,
  output logic             irq
);
  ctlStrobes_t      strobes;
  logic [CNT_W-1:0] cntValue;
  logic             ovFlag;

  perfcnt_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrUser    (wrUser),
    .evtInc    (evtInc),
    .ovFlag    (ovFlag),
    .globalEn  (globalEn),
    .counterEn (counterEn),
    .extIntEn  (extIntEn),
    .strobes   (strobes),
    .irq       (irq)
  );

  perfcnt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .cntValue (cntValue),
    .ovFlag   (ovFlag)
  );

  assign rdData     = cntValue;
  assign rdUserData = cntValue;
endmodule

// File: rtl/perfEventCounter_chk.sv
module perfEventCounter_chk
  import perfcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [INC_W-1:0] evtInc,
  input logic             wrEn,
  input logic             wrUser,
  input logic [CNT_W-1:0] wrData,
  input logic             globalEn,
  input logic             counterEn,
  input logic             extIntEn,
  input logic [CNT_W-1:0] rdData,
  input logic [CNT_W-1:0] rdUserData,
  input logic             irq
);
  localparam int TOP = CNT_W - 1;
  localparam logic [CNT_W-1:0] NEAR_TOP = {CNT_W{1'b1}} - CNT_W'(INC_MAX);

  function automatic logic [CNT_W-1:0] capInc(input logic [INC_W-1:0] v);
    return (int'(v) > INC_MAX) ? CNT_W'(INC_MAX) : CNT_W'(v);
  endfunction

  logic allEn;
  assign allEn = globalEn & counterEn & extIntEn;

  AST_RESET_ZERO: assert property (@(posedge clk) $rose(rstN) |-> rdData == '0); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> rdData == $past(rdData) + capInc($past(evtInc))); // R2

  AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && int'(evtInc) > INC_MAX) |=> rdData == $past(rdData) + CNT_W'(INC_MAX)); // R3

  AST_OV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && rdData[TOP] && rdData < NEAR_TOP) |=> rdData[TOP]); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == $past(wrData)); // R6

  AST_USER_WR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrUser && !wrEn) |=> rdData == $past(rdData) + capInc($past(evtInc))); // R7

  AST_ALIAS_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    rdUserData == rdData); // R8

  AST_IRQ_GATING: assert property (@(posedge clk) disable iff (!rstN)
    irq == (rdData[TOP] & allEn)); // R9

  AST_LOAD_OVF_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[TOP] && !rdData[TOP] && allEn) ##1 allEn |-> irq); // R10
endmodule

bind perfEventCounter perfEventCounter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/perfEventCounter_bench.sv
module perfEventCounter_bench;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    evtInc = '0;
  logic          wrEn = 1'b0;
  logic          wrUser = 1'b0;
  logic [CW-1:0] wrData = '0;
  logic          globalEn = 1'b0;
  logic          counterEn = 1'b0;
  logic          extIntEn = 1'b0;
  logic [CW-1:0] rdData;
  logic [CW-1:0] rdUserData;
  logic          irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [CW-1:0] model = '0;

  always #10 clk = ~clk;

  perfEventCounter u_perfEventCounter (.*);

  function automatic logic [CW-1:0] expStep(input logic [2:0] v);
    return (v > 3'd4) ? 32'd4 : {29'd0, v};
  endfunction

  function automatic logic [CW-1:0] expNext(input logic [CW-1:0] cur, input logic we,
                                            input logic [CW-1:0] wd, input logic [2:0] v);
    return we ? wd : cur + expStep(v);
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at the falling edge, then check after the rising edge.
  task automatic step(input string tag, input logic [2:0] v, input logic we, input logic wu,
                      input logic [CW-1:0] wd, input logic g, input logic c, input logic e);
    evtInc = v; wrEn = we; wrUser = wu; wrData = wd;
    globalEn = g; counterEn = c; extIntEn = e;
    @(posedge clk);
    model = expNext(model, we, wd, v);
    #5;
    check(tag, rdData, model);
    check("R8 alias", rdUserData, model);
    check("R9 irq", {31'd0, irq}, {31'd0, model[CW-1] & g & c & e});
    @(negedge clk);
  endtask

  task automatic load(input logic [CW-1:0] v);
    step("R6 load", 3'd0, 1'b1, 1'b0, v, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset", rdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", rdData, 32'd0);

    // R2: every legal step
    for (int i = 0; i <= 4; i++) step("R2 step", 3'(i), 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    // R3: oversize steps clamp to 4
    for (int i = 5; i <= 7; i++) step("R3 clamp", 3'(i), 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);

    // R5: crossing the halfway point, interrupt masked then enabled
    load(32'h7FFF_FFFE);
    step("R5 cross", 3'd2, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0);
    check("R5 top set", {31'd0, rdData[31]}, 32'd1);
    step("R5 masked counting", 3'd3, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b1);
    step("R9 irq enabled", 3'd1, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1);
    check("R9 irq high", {31'd0, irq}, 32'd1);

    // R4: wraps that straddle the maximum
    load(32'hFFFF_FFFE);
    step("R4 wrap by 4", 3'd4, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1);
    check("R4 top clear", {31'd0, rdData[31]}, 32'd0);
    load(32'hFFFF_FFFD);
    step("R4 wrap by 3 to zero", 3'd3, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    load(32'hFFFF_FFFF);
    step("R4 wrap by 2", 3'd2, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    load(32'hFFFF_FFFF);
    step("R4 wrap by 1", 3'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);

    // R6: write and increment in the same cycle
    step("R6 write wins", 3'd4, 1'b1, 1'b0, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
    // R7: user alias write ignored
    step("R7 user write dropped", 3'd2, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0);
    step("R7 user write no step", 3'd0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0);

    // R10: load an overflowed value with all enables set
    load(32'h0000_0010);
    step("R10 load ovf", 3'd3, 1'b1, 1'b0, 32'h8000_0005, 1'b1, 1'b1, 1'b1);
    check("R10 irq at once", {31'd0, irq}, 32'd1);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0]    rv;
      logic          rwe, rwu, rg, rc, re;
      logic [CW-1:0] rwd;
      rv  = 3'($urandom_range(0, 7));
      rwe = ($urandom_range(0, 15) == 0);
      rwu = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 3))
        0: rwd = 32'hFFFF_FFFF - 32'($urandom_range(0, 6));
        1: rwd = 32'h7FFF_FFFF - 32'($urandom_range(0, 6));
        default: rwd = $urandom();
      endcase
      rg = 1'($urandom()); rc = 1'($urandom()); re = 1'($urandom());
      step("R2 random", rv, rwe, rwu, rwd, rg, rc, re);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule